// File: doc/BRIEF.md
# Write-Only Two-Wire Trim Register Slave

This block is a slave on a two-wire serial bus (clock line and data line) that only accepts writes. A fast system clock samples both bus lines through two-flop synchronizers. Start and stop conditions are found on the synchronized lines, and each frame is then decoded byte by byte. The first byte carries a fixed 7-bit device address and a direction bit. The second byte loads an internal register pointer. Every later byte is stored at the pointer, and the pointer then advances by one.

Each accepted byte is acknowledged by pulling the data line low through an open-drain enable for the whole ninth clock period. A frame with the wrong address or a read request gets no acknowledge and is ignored until the next start or stop. One location of the internal register file controls a crystal load-capacitance trim. Its contents appear at all times on an 8-bit output. Every stored byte is also reported through a one-cycle write strobe that carries its address and data.

Top module: `trim_reg_slave`

## Requirements
- R1: After reset the trim output is 8'h00, the data-line pull-down enable is low and the write strobe is low.
- R2: A first byte equal to 8'hD2 (address 7'b1101001 sent MSB first, then direction bit 0) is acknowledged: the pull-down enable is high while the clock line is high during the ninth clock of that byte.
- R3: A first byte whose 7-bit address differs from 7'b1101001 gets no acknowledge, and no byte of that frame is acknowledged or stored.
- R4: A first byte with the correct address and direction bit 1 (8'hD3) gets no acknowledge, and no byte of that frame is acknowledged or stored.
- R5: The second byte of an accepted frame sets the pointer, and the third byte is stored at that pointer. Each stored byte pulses the write strobe for exactly one system clock, with its address and data on the write address and data outputs.
- R6: Each further data byte is stored at the next pointer value, and the pointer wraps from 8'hFF to 8'h00.
- R7: Register address 8'h13 holds the trim value, which can take any value from 8'h00 to 8'hFF. Its contents are driven continuously on the trim output.
- R8: After a stop condition, bytes clocked without a new start are neither acknowledged nor stored.
- R9: A repeated start in the middle of a frame restarts decoding, so the next byte is taken as the device address again and any earlier pointer setting is dropped.
- R10: The pull-down enable is released after the falling clock edge that ends the ninth clock, and it is low during the following clock-low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull the data line low when 1 (open-drain) |
| trim_o | output | 8 | Contents of the trim register |
| wr_stb | output | 1 | One-cycle pulse for each stored byte |
| wr_addr | output | 8 | Register address of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
The bench sends a burst that starts at pointer 8'hFE. A design without the wrap, or one that increments before storing, would place the bytes at the wrong addresses. It sends frames with a wrong address, with a read request, and with no start after a stop. A slave that decodes too loosely would acknowledge these frames or store their bytes and disturb the trim output. It also issues a repeated start after a pointer byte. A design that kept the old frame state would treat the new address byte as data or keep the stale pointer. Last, it checks the data line in the low period after each acknowledge, which shows an enable held one period too long.

// File: rtl/trim_reg_slave.sv
module trim_reg_slave #(
  parameter int             PW        = 8,
  parameter logic [6:0]     DEV_ADDR  = 7'b1101001,
  parameter logic [PW-1:0]  TRIM_ADDR = 8'h13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [7:0]    trim_o,
  output logic          wr_stb,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int DEPTH = 1 << PW;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_PTR, S_DATA, S_SKIP} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic          ackph;
  logic [PW-1:0] ptr;
  logic [7:0]    regs [DEPTH];

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire active   = (st == S_DEV) || (st == S_PTR) || (st == S_DATA);

  assign trim_o = regs[TRIM_ADDR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ackph   <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        st     <= S_DEV;
        cnt    <= '0;
        ackph  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        cnt    <= '0;
        ackph  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise && !ackph && cnt < 4'd8) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (scl_fall) begin
          if (ackph) begin
            ackph  <= 1'b0;
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (st == S_DEV)      st <= S_PTR;
            else if (st == S_PTR) st <= S_DATA;
          end else if (cnt == 4'd8) begin
            case (st)
              S_DEV: begin
                if (sh == {DEV_ADDR, 1'b0}) begin
                  ackph  <= 1'b1;
                  sda_oe <= 1'b1;
                end else begin
                  st <= S_SKIP;
                end
              end
              S_PTR: begin
                ptr    <= sh[PW-1:0];
                ackph  <= 1'b1;
                sda_oe <= 1'b1;
              end
              default: begin
                regs[ptr] <= sh;
                wr_stb    <= 1'b1;
                wr_addr   <= ptr;
                wr_data   <= sh;
                ptr       <= ptr + 1'b1;
                ackph     <= 1'b1;
                sda_oe    <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  // R5: the strobe lasts one system clock
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R7: a byte stored at the trim address shows at once on the trim output
  a_r7_trim_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == TRIM_ADDR) |-> (trim_o == wr_data));

  // R7: the trim output changes only through a store
  a_r7_trim_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(trim_o));

  // R3, R4: an ignored frame never pulls the line
  a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);

  // R8: a stop releases the line
  a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);

  // R10: the pull-down is released only by a clock fall or a frame boundary
  a_r10_release_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_c || stop_c));

  // R2: the acknowledge starts on a clock fall
  a_r2_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
endmodule

// File: tb/tb_trim_reg_slave.sv
module tb_trim_reg_slave;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_stb;
  logic [7:0] trim_o, wr_addr, wr_data;
  logic sda_line;

  int total = 0;
  int bad = 0;
  logic [15:0] expq [$];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  trim_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .trim_o(trim_o), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5 unexpected store", {wr_addr, wr_data}, 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk({wr_addr, wr_data} == e, "R5/R6 stored addr,data", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF / 2);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b0; wt(HALF / 2);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wt(HALF / 2);
    sda_m = 1'b0; wt(HALF / 2);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send(input logic [7:0] b, input bit ack, input string tag);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wt(HALF / 2);
      sda_m = b[i]; wt(HALF / 2);
      scl_m = 1'b1; wt(HALF);
    end
    scl_m = 1'b0; wt(HALF / 2);
    sda_m = 1'b1; wt(HALF / 2);
    scl_m = 1'b1; wt(HALF / 2);
    chk(sda_oe == ack, tag, sda_oe, ack);
    wt(HALF / 2);
    scl_m = 1'b0; wt(HALF / 2);
    if (ack) chk(sda_oe == 1'b0, "R10 release after ninth clock", sda_oe, 0);
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] d);
    expq.push_back({a, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wt(5);
    chk(trim_o == 8'h00, "R1 trim reset", trim_o, 0);
    chk(sda_oe == 1'b0, "R1 pull-down reset", sda_oe, 0);
    chk(wr_stb == 1'b0, "R1 strobe reset", wr_stb, 0);
    rst_n = 1'b1;
    wt(10);

    // R2 R5 R7: single write to trim
    bus_start();
    send(8'hD2, 1, "R2 address ack");
    send(8'h13, 1, "R5 pointer ack");
    push(8'h13, 8'hA5);
    send(8'hA5, 1, "R5 data ack");
    bus_stop();
    chk(trim_o == 8'hA5, "R7 trim value", trim_o, 8'hA5);

    // R6: burst with wrap
    bus_start();
    send(8'hD2, 1, "R6 address ack");
    send(8'hFE, 1, "R6 pointer ack");
    push(8'hFE, 8'h11); send(8'h11, 1, "R6 data0 ack");
    push(8'hFF, 8'h22); send(8'h22, 1, "R6 data1 ack");
    push(8'h00, 8'h33); send(8'h33, 1, "R6 data2 ack");
    bus_stop();

    // R3: wrong address
    bus_start();
    send(8'hD4, 0, "R3 no ack wrong address");
    send(8'h13, 0, "R3 no ack pointer");
    send(8'h00, 0, "R3 no ack data");
    bus_stop();
    chk(trim_o == 8'hA5, "R3 trim untouched", trim_o, 8'hA5);

    // R4: read request
    bus_start();
    send(8'hD3, 0, "R4 no ack read");
    send(8'h13, 0, "R4 no ack pointer");
    send(8'h44, 0, "R4 no ack data");
    bus_stop();
    chk(trim_o == 8'hA5, "R4 trim untouched", trim_o, 8'hA5);

    // R8: bytes after stop with no start
    send(8'hD2, 0, "R8 no ack without start");
    send(8'h13, 0, "R8 no ack pointer");
    send(8'h55, 0, "R8 no ack data");
    bus_stop();
    chk(trim_o == 8'hA5, "R8 trim untouched", trim_o, 8'hA5);

    // R9: repeated start drops earlier pointer
    bus_start();
    send(8'hD2, 1, "R9 first address ack");
    send(8'h13, 1, "R9 first pointer ack");
    bus_start();
    send(8'hD2, 1, "R9 address ack after restart");
    send(8'h20, 1, "R9 new pointer ack");
    push(8'h20, 8'h5C); send(8'h5C, 1, "R9 data ack");
    bus_stop();
    chk(trim_o == 8'hA5, "R9 trim untouched", trim_o, 8'hA5);

    // R7: extreme trim values
    bus_start();
    send(8'hD2, 1, "R7 address ack");
    send(8'h13, 1, "R7 pointer ack");
    push(8'h13, 8'hFF); send(8'hFF, 1, "R7 data ack");
    bus_stop();
    chk(trim_o == 8'hFF, "R7 trim max", trim_o, 8'hFF);
    bus_start();
    send(8'hD2, 1, "R7 address ack 2");
    send(8'h13, 1, "R7 pointer ack 2");
    push(8'h13, 8'h00); send(8'h00, 1, "R7 data ack 2");
    bus_stop();
    chk(trim_o == 8'h00, "R7 trim min", trim_o, 0);

    wt(10);
    chk(expq.size() == 0, "R5 all expected stores seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule